// File: doc/BRIEF.md
# Multi-Mode Four-Digit Timekeeper

This block is a BCD timekeeping core. It holds one register of four decimal digits and updates it in one of four modes, which level inputs select: clock count, time setting, stopwatch and countdown. A free-running prescaler divides the fast system clock into a one-second tick. A second free-running prescaler gives a tick at one tenth of that period. The digits leave the block as four 4-bit BCD values. Segment decoding is done elsewhere.

In clock and stopwatch modes the digits form a minutes:seconds value that counts up once per second while the run input is high. In time-setting mode each of four active-low keys advances its own digit. Countdown mode counts the four-digit decimal value down once per tenth tick and stops at zero. Dropping the master count enable clears the digits. A separate indicator output lights whenever the units-of-seconds digit is zero. The tick divisor is a parameter, so simulation can run with a small value.

Top module: `tk4_core`

## Requirements
- R1: While `rst_n` is low, all four digits are 0 and `led` is 1. The prescalers and key samplers also return to their initial state.
- R2: With `rst_n` high, a clock edge that samples `count_en` low sets all four digits to 0, whatever the mode inputs are.
- R3: Both prescalers run freely from reset in every mode. The second tick is high for one cycle in every `TICK_DIV` cycles, on cycle number `TICK_DIV` after reset release. The tenth tick is high for one cycle in every `TICK_DIV/10` cycles.
- R4: The digits are ordered as `digit0` = units of seconds, `digit1` = tens of seconds, `digit2` = units of minutes and `digit3` = tens of minutes. In clock mode with `run` high, each second tick adds one second. `digit1` and `digit3` wrap to 0 after reaching 5 or more, so 59:59 is followed by 00:00.
- R5: In clock mode and stopwatch mode, `run` low holds the digits unchanged. Raising `run` again continues counting from the held value.
- R6: Stopwatch mode counts in the same minutes:seconds manner as clock mode, and is gated by `run` in the same way.
- R7: In set mode, a high-to-low transition on `key_n[i]` adds one to digit i, and 9 wraps to 0. The clock edge that first samples the key low starts the press. The digit changes at the next clock edge. A key held low for any length of time gives exactly one increment.
- R8: Key presses have no effect in any mode other than the selected set mode.
- R9: In countdown mode, each tenth tick lowers the four-digit decimal value (`digit3` most significant) by one while the value is non-zero. A digit at 0 borrows from the next digit up and reloads as 9. At 0000 the value holds. `run` has no effect in this mode.
- R10: Mode priority is `down_mode`, then `stop_mode`, then `set_mode`, then clock count. Changing mode does not clear the digits.
- R11: `led` is 1 exactly when `digit0` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Master enable; low clears the digits |
| run | input | 1 | Run/pause for clock and stopwatch modes |
| set_mode | input | 1 | Selects time setting |
| stop_mode | input | 1 | Selects stopwatch |
| down_mode | input | 1 | Selects countdown |
| key_n | input | 4 | Active-low per-digit set keys; bit i drives digit i |
| digit0 | output | 4 | Units of seconds (BCD) |
| digit1 | output | 4 | Tens of seconds (BCD) |
| digit2 | output | 4 | Units of minutes (BCD) |
| digit3 | output | 4 | Tens of minutes (BCD) |
| led | output | 1 | High when digit0 is 0 |

## Verification
Two pairs of events can land on the same clock edge. A key press can coincide with a second tick while both the stopwatch input and the set input are high. A tick can also coincide with the edge that drops the enable or changes mode. The bench provokes the first pair by pressing a key during a running stopwatch that has the set input raised, and the second by pulling the enable or switching modes at arbitrary points in the tick phase. A behavioural reference model decides each cycle which event wins, following the priority and clear rules, and compares its four digits and indicator with the outputs on every clock.

// File: rtl/tk4_pkg.sv
package tk4_pkg;

  typedef logic [3:0] bcd_t;
  typedef logic [3:0][3:0] digits_t;

  typedef enum logic [1:0] {
    MODE_CLOCK = 2'd0,
    MODE_SET   = 2'd1,
    MODE_STOP  = 2'd2,
    MODE_DOWN  = 2'd3
  } mode_e;

  // Priority: countdown, stopwatch, set, clock
  function automatic mode_e pick_mode(input logic down, input logic stop, input logic set);
    if (down)      return MODE_DOWN;
    else if (stop) return MODE_STOP;
    else if (set)  return MODE_SET;
    else           return MODE_CLOCK;
  endfunction

  function automatic bcd_t wrap9_inc(input bcd_t x);
    return (x >= 4'd9) ? 4'd0 : x + 4'd1;
  endfunction

  function automatic logic is_zero(input digits_t d);
    return (d == '0);
  endfunction

  // Minutes:seconds increment; odd positions are tens digits, limit 5
  function automatic digits_t mmss_inc(input digits_t d);
    digits_t r;
    logic    carry;
    bcd_t    lim;
    r     = d;
    carry = 1'b1;
    for (int i = 0; i < 4; i++) begin
      lim = (i % 2 == 1) ? 4'd5 : 4'd9;
      if (carry) begin
        if (r[i] >= lim) r[i] = 4'd0;
        else begin
          r[i]  = r[i] + 4'd1;
          carry = 1'b0;
        end
      end
    end
    return r;
  endfunction

  // Plain four-digit decimal decrement with borrow
  function automatic digits_t dec4(input digits_t d);
    digits_t r;
    logic    borrow;
    r      = d;
    borrow = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (borrow) begin
        if (r[i] == 4'd0) r[i] = 4'd9;
        else begin
          r[i]   = r[i] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tk4_prescaler.sv
module tk4_prescaler #(
  parameter int DIV = 27_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tk4_keyedge.sv
module tk4_keyedge #(
  parameter int NKEYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKEYS-1:0] key_n,
  output logic [NKEYS-1:0] press
);
  for (genvar g = 0; g < NKEYS; g++) begin : g_key
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= key_n[g];
        s2_q <= s1_q;
      end
    end
    assign press[g] = s2_q & ~s1_q;
  end
endmodule

// File: rtl/tk4_digits.sv
module tk4_digits
  import tk4_pkg::*;
#(
  parameter int NKEYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             run,
  input  mode_e            mode,
  input  logic             sec_tick,
  input  logic             tenth_tick,
  input  logic [NKEYS-1:0] press,
  output digits_t          digits
);
  digits_t digits_q, digits_d;

  always_comb begin
    digits_d = digits_q;
    if (!count_en) begin
      digits_d = '0;
    end else begin
      unique case (mode)
        MODE_DOWN:
          if (tenth_tick && !is_zero(digits_q)) digits_d = dec4(digits_q);
        MODE_CLOCK, MODE_STOP:
          if (run && sec_tick) digits_d = mmss_inc(digits_q);
        MODE_SET:
          for (int i = 0; i < NKEYS; i++)
            if (press[i]) digits_d[i] = wrap9_inc(digits_q[i]);
        default: digits_d = digits_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) digits_q <= '0;
    else        digits_q <= digits_d;
  end

  assign digits = digits_q;
endmodule

// File: rtl/tk4_core.sv
module tk4_core
  import tk4_pkg::*;
#(
  parameter int TICK_DIV = 27_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       count_en,
  input  logic       run,
  input  logic       set_mode,
  input  logic       stop_mode,
  input  logic       down_mode,
  input  logic [3:0] key_n,
  output logic [3:0] digit0,
  output logic [3:0] digit1,
  output logic [3:0] digit2,
  output logic [3:0] digit3,
  output logic       led
);
  localparam int TENTH_DIV = (TICK_DIV >= 10) ? TICK_DIV / 10 : 1;
  localparam int NKEYS     = 4;

  logic             sec_tick;
  logic             tenth_tick;
  logic [NKEYS-1:0] press;
  mode_e            mode;
  digits_t          digits;

  assign mode = pick_mode(down_mode, stop_mode, set_mode);

  tk4_prescaler #(.DIV(TICK_DIV)) u_sec (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick)
  );

  tk4_prescaler #(.DIV(TENTH_DIV)) u_tenth (
    .clk(clk), .rst_n(rst_n), .tick(tenth_tick)
  );

  tk4_keyedge #(.NKEYS(NKEYS)) u_keys (
    .clk(clk), .rst_n(rst_n), .key_n(key_n), .press(press)
  );

  tk4_digits #(.NKEYS(NKEYS)) u_digits (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .run(run),
    .mode(mode), .sec_tick(sec_tick), .tenth_tick(tenth_tick),
    .press(press), .digits(digits)
  );

  assign digit0 = digits[0];
  assign digit1 = digits[1];
  assign digit2 = digits[2];
  assign digit3 = digits[3];
  assign led    = (digits[0] == 4'd0);
endmodule

// File: rtl/tk4_chk.sv
module tk4_chk
  import tk4_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       count_en,
  input logic       run,
  input mode_e      mode,
  input logic       sec_tick,
  input logic       tenth_tick,
  input logic [3:0] press,
  input logic [3:0] digit0,
  input logic [3:0] digit1,
  input logic [3:0] digit2,
  input logic [3:0] digit3,
  input logic       led
);
  logic [15:0] val;
  assign val = {digit3, digit2, digit1, digit0};

  AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> val == 16'h0000);                                   // R2

  AST_SEC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);                                           // R3

  AST_TENTH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tenth_tick |=> !tenth_tick);                                       // R3

  AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    digit0 <= 4'd9 && digit1 <= 4'd9 && digit2 <= 4'd9 && digit3 <= 4'd9); // R4

  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !run && (mode == MODE_CLOCK || mode == MODE_STOP)) ##1 count_en
    |-> $stable(val));                                                 // R5

  AST_SET_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && mode == MODE_SET && press[0] && digit0 == 4'd9) ##1 count_en
    |-> digit0 == 4'd0);                                               // R7

  AST_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && mode == MODE_SET && press == 4'b0000) ##1 count_en
    |-> $stable(val));                                                 // R7

  AST_DOWN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && mode == MODE_DOWN && val == 16'h0000) ##1 count_en
    |-> val == 16'h0000);                                              // R9

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && mode == MODE_DOWN && !tenth_tick) ##1 count_en
    |-> $stable(val));                                                 // R9

  AST_LED_RESET: assert property (@(posedge clk)
    !rst_n |-> led);                                                   // R1
endmodule

bind tk4_core tk4_chk u_chk (
  .clk(clk), .rst_n(rst_n), .count_en(count_en), .run(run), .mode(mode),
  .sec_tick(sec_tick), .tenth_tick(tenth_tick), .press(press),
  .digit0(digit0), .digit1(digit1), .digit2(digit2), .digit3(digit3),
  .led(led)
);

// File: tb/tk4_core_test.sv
module tk4_core_test;
  localparam int DIV   = 20;
  localparam int TDIV  = DIV / 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       count_en = 1'b0, run = 1'b0;
  logic       set_mode = 1'b0, stop_mode = 1'b0, down_mode = 1'b0;
  logic [3:0] key_n = 4'hF;
  logic [3:0] digit0, digit1, digit2, digit3;
  logic       led;

  int    tests = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 0;

  tk4_core #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .run(run),
    .set_mode(set_mode), .stop_mode(stop_mode), .down_mode(down_mode),
    .key_n(key_n), .digit0(digit0), .digit1(digit1), .digit2(digit2),
    .digit3(digit3), .led(led)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  int md[4] = '{0, 0, 0, 0};
  int sc = 0, tc = 0;
  bit [3:0] mk1 = 4'hF, mk2 = 4'hF;

  function automatic logic [15:0] mval();
    return {md[3][3:0], md[2][3:0], md[1][3:0], md[0][3:0]};
  endfunction

  always @(posedge clk) begin
    bit st, tt;
    bit [3:0] pr;
    int v;
    if (!rst_n) begin
      foreach (md[i]) md[i] = 0;
      sc = 0; tc = 0; mk1 = 4'hF; mk2 = 4'hF;
    end else begin
      st = (sc == DIV - 1);
      tt = (tc == TDIV - 1);
      pr = mk2 & ~mk1;
      if (!count_en) begin
        foreach (md[i]) md[i] = 0;
      end else if (down_mode) begin
        v = md[3] * 1000 + md[2] * 100 + md[1] * 10 + md[0];
        if (tt && v > 0) begin
          v = v - 1;
          md[0] = v % 10; md[1] = (v / 10) % 10;
          md[2] = (v / 100) % 10; md[3] = v / 1000;
        end
      end else if (stop_mode || !set_mode) begin
        if (run && st) begin
          md[0]++;
          if (md[0] == 10) begin
            md[0] = 0;
            if (md[1] >= 5) begin
              md[1] = 0;
              md[2]++;
              if (md[2] == 10) begin
                md[2] = 0;
                md[3] = (md[3] >= 5) ? 0 : md[3] + 1;
              end
            end else md[1]++;
          end
        end
      end else begin
        for (int i = 0; i < 4; i++) if (pr[i]) md[i] = (md[i] + 1) % 10;
      end
      sc = (sc + 1) % DIV;
      tc = (tc + 1) % TDIV;
      mk2 = mk1;
      mk1 = key_n;
    end
  end

  function automatic logic [15:0] dval();
    return {digit3, digit2, digit1, digit0};
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (dval() !== mval() || led !== (md[0] == 0)) begin
        fails++;
        $display("FAIL %s model: actual %h led %b expected %h led %b",
                 cur_req, dval(), led, mval(), (md[0] == 0));
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic press_key(input int k, input int hold);
    @(negedge clk) key_n[k] = 1'b0;
    repeat (hold) @(negedge clk);
    key_n[k] = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_digits(input int a3, input int a2, input int a1, input int a0);
    int n[4];
    n = '{a0, a1, a2, a3};
    @(negedge clk) begin count_en = 0; down_mode = 0; stop_mode = 0; set_mode = 1; end
    @(negedge clk) count_en = 1;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < n[k]; j++) press_key(k, 1);
  endtask

  task automatic measure_period(input string tag);
    logic [15:0] v0;
    int cnt;
    @(negedge clk) v0 = dval();
    while (dval() == v0) @(negedge clk);
    v0 = dval(); cnt = 0;
    while (dval() == v0 && cnt < 4 * DIV) begin @(negedge clk); cnt++; end
    check(tag, 16'(cnt), 16'(DIV));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (4) @(negedge clk);
    check("R1 digits", dval(), 16'h0000);
    check("R1 led", {15'd0, led}, 16'd1);
    rst_n = 1;

    // R3: first second tick on cycle DIV after release; clock runs
    cur_req = "R3";
    count_en = 1; run = 1;
    repeat (DIV - 1) @(negedge clk);
    check("R3 before tick", dval(), 16'h0000);
    @(negedge clk);
    check("R3 first tick", dval(), 16'h0001);
    cur_req = "R4";
    measure_period("R3 second period");
    repeat (DIV * 75) @(negedge clk);
    check("R11 led after run", {15'd0, led}, {15'd0, digit0 == 4'd0});

    // R5: pause and resume
    cur_req = "R5";
    run = 0;
    @(negedge clk) held = dval();
    repeat (3 * DIV) @(negedge clk);
    check("R5 pause hold", dval(), held);
    run = 1;
    repeat (3 * DIV) @(negedge clk);

    // R6: stopwatch counting, pause, enable drop
    cur_req = "R6";
    stop_mode = 1;
    measure_period("R6 stopwatch period");
    repeat (7 * DIV + 3) @(negedge clk);
    cur_req = "R2";
    count_en = 0;
    @(negedge clk);
    check("R2 clear", dval(), 16'h0000);
    count_en = 1;
    repeat (DIV + 5) @(negedge clk);

    // R7: setting with wrap and held key
    cur_req = "R7";
    set_digits(0, 0, 0, 0);
    for (int j = 0; j < 10; j++) press_key(0, 1);
    check("R7 wrap 9 to 0", dval(), 16'h0000);
    press_key(0, 30);
    check("R7 held key one step", dval(), 16'h0001);
    @(negedge clk) key_n[2] = 1'b0;
    @(negedge clk);
    check("R7 before update", dval(), 16'h0001);
    @(negedge clk);
    check("R7 after update", dval(), 16'h0101);
    key_n[2] = 1'b1;
    set_digits(5, 9, 5, 9);
    check("R7 set 59:59", dval(), 16'h5959);

    // R8: keys ignored in clock mode (paused)
    cur_req = "R8";
    set_mode = 0; run = 0;
    press_key(0, 2);
    press_key(3, 2);
    check("R8 keys ignored", dval(), 16'h5959);

    // R4: rollover
    cur_req = "R4";
    run = 1;
    for (int c = 0; c < DIV + 5; c++) begin
      @(negedge clk);
      if (dval() != 16'h5959) break;
    end
    check("R4 59:59 rollover", dval(), 16'h0000);

    // R9: countdown with borrow across all digits, floor, run ignored
    cur_req = "R9";
    set_digits(1, 0, 0, 0);
    @(negedge clk) begin set_mode = 0; down_mode = 1; run = 0; end
    for (int c = 0; c < 3 * TDIV; c++) begin
      @(negedge clk);
      if (dval() != 16'h1000) break;
    end
    check("R9 borrow 1000->0999", dval(), 16'h0999);
    repeat (1000 * TDIV + 50) @(negedge clk);
    check("R9 floor 0000", dval(), 16'h0000);
    check("R11 led at zero", {15'd0, led}, 16'd1);

    // R10: priority and no clear on mode change
    cur_req = "R10";
    set_mode = 1;
    press_key(0, 2);
    check("R10 down over set", dval(), 16'h0000);
    down_mode = 0;
    press_key(1, 2);
    check("R10 set active after down", dval(), 16'h0010);
    stop_mode = 1; run = 1;
    press_key(3, 2);
    check("R10 stop over set", {12'd0, digit3}, 16'h0000);
    repeat (5 * DIV + 7) @(negedge clk);
    held = dval();
    stop_mode = 0; run = 0;
    @(negedge clk);
    check("R10 no clear on change", dval(), held);
    count_en = 0; set_mode = 0; down_mode = 1;
    repeat (3) @(negedge clk);
    count_en = 1; down_mode = 0; stop_mode = 1; run = 1;
    repeat (4 * DIV + 3) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule